// File: doc/BRIEF.md
# Serial Buffer-Load Command Receiver

This block sits on the slave side of a four-wire serial memory interface and carries out the command that fills an on-chip SRAM staging buffer. It samples the serial clock, chip select and serial data input with its own system clock. Once chip select goes low it collects an 8-bit command code. If the code selects the buffer-load command, it then takes a 24-bit address field and after that an open-ended run of data bytes.

Each complete data byte is presented on a single-cycle write port to the buffer. The first byte goes to the start address taken from the address field, and each further byte goes to the next location. Past the last location the address returns to zero. The transfer runs for as long as chip select stays low. Bits that do not make up a whole byte when chip select rises are dropped. A command code the block does not serve makes it ignore the rest of that selection.

Top module: `spi_bufwr_top`

## Requirements
- R1: Serial input is sampled on each rising edge of the serial clock while chip select is low, most significant bit first. The first 8 bits form the command code, and only code 0x84 starts a buffer load.
- R2: After the command code come 24 address bits. The first 15 have no effect. The last 9 give the start byte address, and a value of DEPTH (264) or above is reduced by DEPTH once (300 starts at 36).
- R3: Each 8 data bits after the address field give exactly one write: `buf_we` is high for one clock cycle, with `buf_wdata` holding the byte (first bit in bit 7) and `buf_addr` its location.
- R4: The first data byte is written to the start address, and each following byte to the previous address plus one.
- R5: The location after DEPTH-1 (263) is 0, and `buf_addr` never reaches DEPTH.
- R6: Data bytes keep being written, with no count limit, until chip select rises.
- R7: Fewer than 8 data bits received when chip select rises produce no write. Neither does chip select rising during the code or address field.
- R8: A command code other than 0x84 produces no write for the rest of that selection. The next selection is decoded normally.
- R9: While reset is asserted, `buf_we` is 0 and `buf_addr` and `buf_wdata` are all zero.
- R10: Serial clock edges while chip select is high cause no write and do not advance the bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from the host |
| buf_addr | output | ADDR_W (9) | Buffer byte address of the current write |
| buf_wdata | output | 8 | Byte to store |
| buf_we | output | 1 | One-cycle write strobe |

## Verification
The checker tests four properties on every clock cycle:
- every write strobe lasts exactly one cycle;
- a write address is always below the buffer depth;
- each write within a selection lands one location past the previous write, with the step back to zero;
- no strobe appears while chip select is high or while a refused command is being ignored.

Only the bench scenarios can show the rest:
- which command code is accepted;
- that the 15 leading address bits have no effect;
- that the start address is taken correctly, including reduction of values at or above the depth;
- the byte values written;
- that a trailing partial byte or a cut-off header is dropped.

// File: rtl/spi_bufwr_pkg.sv
package spi_bufwr_pkg;

  parameter int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_ADR  = 2'd1,
    ST_DAT  = 2'd2,
    ST_SKIP = 2'd3
  } bw_state_e;

endpackage

// File: rtl/spi_bufwr_sync.sv
module spi_bufwr_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_bufwr_rx.sv
module spi_bufwr_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic si_s,
  output logic bit_stb,
  output logic bit_val,
  output logic cs_active
);

  logic sck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;

  // a rising serial clock edge counts only while the device is selected
  assign cs_active = ~cs_n_s;
  assign bit_stb   = cs_active & sck_s & ~sck_q;
  assign bit_val   = si_s;

endmodule

// File: rtl/spi_bufwr_top.sv
module spi_bufwr_top
  import spi_bufwr_pkg::*;
#(
  parameter int         DEPTH       = 264,
  parameter logic [7:0] OPCODE      = 8'h84,
  parameter int         ADR_BITS    = 24,
  parameter int         SYNC_STAGES = 2,
  localparam int        ADDR_W      = $clog2(DEPTH),
  localparam int        CNT_W       = $clog2(ADR_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [BYTE_W-1:0] buf_wdata,
  output logic              buf_we
);

  // start address at or above the depth is reduced once
  function automatic logic [ADDR_W-1:0] fold_start(input logic [ADDR_W-1:0] a);
    if (int'(a) >= DEPTH) return ADDR_W'(int'(a) - DEPTH);
    return a;
  endfunction

  // next buffer location with return to zero past the end
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    if (int'(a) >= DEPTH - 1) return '0;
    return a + 1'b1;
  endfunction

  logic [2:0] pins_s;
  logic       bit_stb, bit_val;
  logic       cs_active;
  logic       in_skip;
  logic       byte_done;

  spi_bufwr_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck, cs_n, si}),
    .q    (pins_s)
  );

  spi_bufwr_rx rx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (pins_s[2]),
    .cs_n_s   (pins_s[1]),
    .si_s     (pins_s[0]),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .cs_active(cs_active)
  );

  bw_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [ADDR_W-1:0] adr_sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              we_q;

  logic [BYTE_W-1:0] sh_nxt;
  logic [ADDR_W-1:0] adr_nxt;
  logic              last_byte_bit, last_adr_bit;

  assign sh_nxt        = {sh_q[BYTE_W-2:0], bit_val};
  assign adr_nxt       = {adr_sh_q[ADDR_W-2:0], bit_val};
  assign last_byte_bit = (cnt_q == CNT_W'(BYTE_W - 1));
  assign last_adr_bit  = (cnt_q == CNT_W'(ADR_BITS - 1));
  assign in_skip       = (st_q == ST_SKIP);
  assign byte_done     = bit_stb && (st_q == ST_DAT) && last_byte_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OPC;
      cnt_q    <= '0;
      sh_q     <= '0;
      adr_sh_q <= '0;
      ptr_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      we_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (!cs_active) begin
        st_q  <= ST_OPC;
        cnt_q <= '0;
      end else if (bit_stb) begin
        sh_q <= sh_nxt;
        unique case (st_q)
          ST_OPC: begin
            if (last_byte_bit) begin
              st_q  <= (sh_nxt == OPCODE) ? ST_ADR : ST_SKIP;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADR: begin
            adr_sh_q <= adr_nxt;
            if (last_adr_bit) begin
              st_q  <= ST_DAT;
              ptr_q <= fold_start(adr_nxt);
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DAT: begin
            if (last_byte_bit) begin
              we_q   <= 1'b1;
              addr_q <= ptr_q;
              data_q <= sh_nxt;
              ptr_q  <= step_addr(ptr_q);
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign buf_addr  = addr_q;
  assign buf_wdata = data_q;
  assign buf_we    = we_q;

endmodule

// File: rtl/spi_bufwr_chk.sv
module spi_bufwr_chk #(
  parameter int DEPTH  = 264,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              cs_active,
  input logic              in_skip
);

  logic              have_last_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] expect_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_q      <= '0;
    end else if (!cs_active) begin
      have_last_q <= 1'b0;
    end else if (buf_we) begin
      have_last_q <= 1'b1;
      last_q      <= buf_addr;
    end

  assign expect_nxt = (int'(last_q) == DEPTH - 1) ? '0 : last_q + 1'b1;

  assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> !buf_we);

  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (int'(buf_addr) < DEPTH));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && have_last_q) |-> (buf_addr == expect_nxt));

  assert_quiet_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !buf_we);

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_active) |-> !buf_we);

endmodule

bind spi_bufwr_top spi_bufwr_chk #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .buf_we   (buf_we),
  .buf_addr (buf_addr),
  .cs_active(cs_active),
  .in_skip  (in_skip)
);

// File: tb/spi_bufwr_top_tb_top.sv
`timescale 1ns/1ps
module spi_bufwr_top_tb_top;

  localparam int DEP  = 264;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       si = 1'b0;
  logic [8:0] buf_addr;
  logic [7:0] buf_wdata;
  logic       buf_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_bufwr_top dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we)
  );

  // write log, filled away from the active edge
  logic [8:0] log_a [32];
  logic [7:0] log_d [32];
  int         wr_n = 0;

  always @(negedge clk)
    if (rst_n && buf_we) begin
      if (wr_n < 32) begin
        log_a[wr_n] = buf_addr;
        log_d[wr_n] = buf_wdata;
      end
      wr_n = wr_n + 1;
    end

  typedef struct packed {
    logic [7:0]  opc;
    logic [14:0] dc;
    logic [8:0]  adr;
    logic [5:0]  n;
    logic [7:0]  seed;
    logic [8:0]  xs;
    logic [5:0]  xn;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h84, 15'h0000, 9'd0,   6'd4,  8'h0A, 9'd0,   6'd4 },
    '{8'h84, 15'h7FFF, 9'd100, 6'd3,  8'h84, 9'd100, 6'd3 },
    '{8'h84, 15'h2AAA, 9'd261, 6'd6,  8'hF0, 9'd261, 6'd6 },
    '{8'h83, 15'h0000, 9'd5,   6'd3,  8'h84, 9'd0,   6'd0 },
    '{8'h84, 15'h0000, 9'd300, 6'd2,  8'h55, 9'd36,  6'd2 },
    '{8'h84, 15'h1234, 9'd263, 6'd20, 8'h01, 9'd263, 6'd20},
    '{8'h00, 15'h5555, 9'd7,   6'd4,  8'h84, 9'd0,   6'd0 }
  };

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  function automatic logic [8:0] exp_loc(input logic [8:0] start, input int k);
    return 9'((int'(start) + k) % DEP);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      si  = w[i];
      sck = 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    wr_n = 0;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_log(input logic [8:0] xs, input int xn, input logic [7:0] seed, input string req);
    check(wr_n == xn, {req, " write count"}, wr_n, xn);
    for (int k = 0; k < xn && k < wr_n && k < 32; k++) begin
      check(log_a[k] == exp_loc(xs, k), {req, " address"}, int'(log_a[k]), int'(exp_loc(xs, k)));
      check(log_d[k] == dbyte(seed, k), {req, " data"}, int'(log_d[k]), int'(dbyte(seed, k)));
    end
  endtask

  initial begin
    // R9: outputs held at zero in reset
    wait_clk(3);
    check(buf_we == 1'b0, "R9 we", int'(buf_we), 0);
    check(buf_addr == '0, "R9 addr", int'(buf_addr), 0);
    check(buf_wdata == '0, "R9 data", int'(buf_wdata), 0);
    rst_n = 1'b1;
    wait_clk(5);

    // table walk: R1 R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      cs_low();
      send_bits({VECS[v].opc, VECS[v].dc, VECS[v].adr}, 32);
      for (int b = 0; b < int'(VECS[v].n); b++)
        send_bits({24'h0, dbyte(VECS[v].seed, b)}, 8);
      cs_high();
      check_log(VECS[v].xs, int'(VECS[v].xn), VECS[v].seed, "R3/R4/R5/R8 vector");
    end

    // R7: trailing partial byte dropped
    cs_low();
    send_bits({8'h84, 15'h0, 9'd10}, 32);
    send_bits({24'h0, dbyte(8'h20, 0)}, 8);
    send_bits({24'h0, dbyte(8'h20, 1)}, 8);
    send_bits(32'h15, 5);
    cs_high();
    check_log(9'd10, 2, 8'h20, "R7 partial");

    // R7: selection ends inside the address field, next one decodes (R1)
    cs_low();
    send_bits({8'h84, 15'h0, 9'd0} >> 12, 20);
    cs_high();
    check(wr_n == 0, "R7 cut header", wr_n, 0);
    cs_low();
    send_bits({8'h84, 15'h0, 9'd50}, 32);
    send_bits({24'h0, dbyte(8'h33, 0)}, 8);
    cs_high();
    check_log(9'd50, 1, 8'h33, "R1 after cut");

    // R10: clock edges with chip select high have no effect
    wr_n = 0;
    send_bits({8'h84, 15'h0, 9'd1}, 32);
    send_bits(32'hFF, 8);
    wait_clk(10);
    check(wr_n == 0, "R10 deselected", wr_n, 0);
    cs_low();
    send_bits({8'h84, 15'h0, 9'd2}, 32);
    send_bits({24'h0, dbyte(8'h40, 0)}, 8);
    cs_high();
    check_log(9'd2, 1, 8'h40, "R10 count not advanced");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule